// File: doc/BRIEF.md
# Loopback Mode Switch Controller

This block steers one transceiver channel's receive path between three operating modes: normal reception from the far end, serial loopback (the receiver takes the local transmitter's serial stream), and forward parallel loopback (the pattern-test datapath is enabled through reconfiguration). A host asks for a mode over a valid/acknowledge handshake. The controller then runs a fixed sequence. It applies the new mode enables and waits for the reconfiguration engine when the pattern-test enable changed. It holds the receive PCS digital reset for a guaranteed number of parallel clock cycles. It waits for the word aligner to report lock, and then raises a ready flag.

The receive PCS runs from the recovered clock, and that clock can be unstable while the CDR moves to a new source. For this reason the serial-loopback enable only ever changes while the receive reset is already asserted. When the pattern-test enable changes, the minimum hold period starts only after the reconfiguration engine reports completion. If lock does not arrive within a programmable window, the controller raises an error flag and repeats the reset hold.

Top module: `lpbk_switch_ctrl`

## Requirements
- R1: After rst_n is released, mode_stat is 00, ser_lpbk_en, prbs_mode_en, rx_pcs_rst, chan_ready and align_err are all low, and the controller accepts a request.
- R2: req_ack is high in the same cycle as req_valid only while the controller is idle or ready, and the request is taken at that clock edge. A request made while a switch is in progress gets no acknowledge and waits until chan_ready is high.
- R3: Mode codes on req_mode and mode_stat are 00 normal, 01 serial loopback and 10 forward parallel loopback, with mode_stat = {prbs_mode_en, ser_lpbk_en}. A requested code 11 is taken as normal.
- R4: Any switch that changes ser_lpbk_en asserts rx_pcs_rst in the cycle after acceptance. The enable changes one cycle later, while the reset is still high, and it never changes while rx_pcs_rst is low.
- R5: After the last mode change, or after reconfiguration completes, rx_pcs_rst stays high for exactly max(HOLD_CYC, 2) cycles, and every pulse lasts at least two cycles.
- R6: When prbs_mode_en changes, the controller waits for recfg_done before it starts the hold period. If the serial enable did not also change, rx_pcs_rst stays low until recfg_done is seen.
- R7: After the hold ends, chan_ready rises the cycle after align_lock is sampled high.
- R8: If align_lock is not seen within ALIGN_TMO cycles after the reset is released, align_err is set and another full reset hold is issued. align_err stays set until the next accepted request.
- R9: chan_ready goes low in the cycle after a request is accepted and stays low until the new sequence completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host mode request valid |
| req_mode | input | 2 | Requested mode code |
| req_ack | output | 1 | Request accepted this cycle |
| recfg_done | input | 1 | Reconfiguration operation finished |
| align_lock | input | 1 | Word aligner has found the byte boundary |
| ser_lpbk_en | output | 1 | Serial loopback enable |
| prbs_mode_en | output | 1 | Pattern test mode enable (forward parallel loopback) |
| rx_pcs_rst | output | 1 | Receive PCS digital reset |
| mode_stat | output | 2 | Current mode code |
| chan_ready | output | 1 | Channel aligned in the current mode |
| align_err | output | 1 | An alignment timeout occurred in this sequence |

## Verification
The assertions take for granted that recfg_done comes only after the pattern-test enable has changed. They also assume that align_lock is low whenever rx_pcs_rst is high, as a real aligner under reset behaves. The bench's reconfiguration model pulses recfg_done a fixed number of cycles after it sees prbs_mode_en change. Its aligner model forces lock low during reset and raises it a few cycles after release, or withholds it for a chosen number of releases, which keeps every stimulus inside these assumptions.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_SER  = 2'b01,
    MODE_PAR  = 2'b10
  } lmc_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_WCFG,
    ST_HOLD,
    ST_WALN,
    ST_READY
  } lmc_state_e;

  // Unused code 11 maps to normal operation.
  function automatic lmc_mode_e lmc_decode(input logic [1:0] raw);
    case (raw)
      2'b01:   return MODE_SER;
      2'b10:   return MODE_PAR;
      default: return MODE_NORM;
    endcase
  endfunction

endpackage

// File: rtl/lmc_hold_cnt.sv
module lmc_hold_cnt #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int HOLD_EFF = (HOLD_CYC < 2) ? 2 : HOLD_CYC;
  localparam int CW       = $clog2(HOLD_EFF + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_EFF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (run && (cnt_q != '0));
    cnt_d  = load ? LOAD_VAL : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL); // R5

endmodule

// File: rtl/lmc_align_tmo.sv
module lmc_align_tmo #(
  parameter int ALIGN_TMO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TMO_EFF = (ALIGN_TMO < 1) ? 1 : ALIGN_TMO;
  localparam int CW      = $clog2(TMO_EFF + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_EFF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !run || !expired;
    cnt_d  = run ? (cnt_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LAST);

  AST_TMO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R8

endmodule

// File: rtl/lmc_seq.sv
module lmc_seq
  import lmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       recfg_done,
  input  logic       align_lock,
  input  logic       hold_done,
  input  logic       tmo_exp,
  output logic       req_ack,
  output logic       hold_load,
  output logic       hold_run,
  output logic       tmo_run,
  output logic       ser_en,
  output logic       prbs_en,
  output logic       pcs_rst,
  output logic       ready,
  output logic       err
);
  lmc_state_e state_q, state_d;
  lmc_mode_e  tgt_q, tgt_d;
  logic       ser_q, ser_d, prbs_q, prbs_d;
  logic       keep_q, keep_d, err_q, err_d;
  logic       accept, ser_chg, cfg_chg;

  always_comb begin
    accept  = req_valid && ((state_q == ST_IDLE) || (state_q == ST_READY));
    ser_chg = (tgt_q == MODE_SER) != ser_q;
    cfg_chg = (tgt_q == MODE_PAR) != prbs_q;

    state_d   = state_q;
    tgt_d     = tgt_q;
    ser_d     = ser_q;
    prbs_d    = prbs_q;
    keep_d    = keep_q;
    err_d     = err_q;
    hold_load = 1'b0;

    case (state_q)
      ST_IDLE, ST_READY: begin
        if (accept) begin
          state_d = ST_APPLY;
          tgt_d   = lmc_decode(req_mode);
          err_d   = 1'b0;
        end
      end
      ST_APPLY: begin
        ser_d  = (tgt_q == MODE_SER);
        prbs_d = (tgt_q == MODE_PAR);
        keep_d = ser_chg;
        if (cfg_chg) begin
          state_d = ST_WCFG;
        end else begin
          state_d   = ST_HOLD;
          hold_load = 1'b1;
        end
      end
      ST_WCFG: begin
        if (recfg_done) begin
          state_d   = ST_HOLD;
          hold_load = 1'b1;
        end
      end
      ST_HOLD: begin
        if (hold_done) state_d = ST_WALN;
      end
      ST_WALN: begin
        if (align_lock) begin
          state_d = ST_READY;
        end else if (tmo_exp) begin
          state_d   = ST_HOLD;
          hold_load = 1'b1;
          err_d     = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= MODE_NORM;
      ser_q   <= 1'b0;
      prbs_q  <= 1'b0;
      keep_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      ser_q   <= ser_d;
      prbs_q  <= prbs_d;
      keep_q  <= keep_d;
      err_q   <= err_d;
    end
  end

  assign req_ack  = accept;
  assign hold_run = (state_q == ST_HOLD);
  assign tmo_run  = (state_q == ST_WALN);
  assign ser_en   = ser_q;
  assign prbs_en  = prbs_q;
  assign ready    = (state_q == ST_READY);
  assign err      = err_q;
  assign pcs_rst  = ((state_q == ST_APPLY) && ser_chg) ||
                    ((state_q == ST_WCFG) && keep_q) ||
                    (state_q == ST_HOLD);

  AST_SER_UNDER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_q != $past(ser_q)) |-> pcs_rst); // R4
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_q && prbs_q)); // R3
  AST_READY_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(align_lock)); // R7
  AST_ACK_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !ready); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(tmo_exp)); // R8

endmodule

// File: rtl/lpbk_switch_ctrl.sv
module lpbk_switch_ctrl #(
  parameter int HOLD_CYC  = 2,
  parameter int ALIGN_TMO = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  output logic       req_ack,
  input  logic       recfg_done,
  input  logic       align_lock,
  output logic       ser_lpbk_en,
  output logic       prbs_mode_en,
  output logic       rx_pcs_rst,
  output logic [1:0] mode_stat,
  output logic       chan_ready,
  output logic       align_err
);
  logic hold_load, hold_run, hold_done;
  logic tmo_run, tmo_exp;

  lmc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .recfg_done (recfg_done),
    .align_lock (align_lock),
    .hold_done  (hold_done),
    .tmo_exp    (tmo_exp),
    .req_ack    (req_ack),
    .hold_load  (hold_load),
    .hold_run   (hold_run),
    .tmo_run    (tmo_run),
    .ser_en     (ser_lpbk_en),
    .prbs_en    (prbs_mode_en),
    .pcs_rst    (rx_pcs_rst),
    .ready      (chan_ready),
    .err        (align_err)
  );

  lmc_hold_cnt #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (hold_load),
    .run   (hold_run),
    .done  (hold_done)
  );

  lmc_align_tmo #(.ALIGN_TMO(ALIGN_TMO)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tmo_run),
    .expired (tmo_exp)
  );

  assign mode_stat = {prbs_mode_en, ser_lpbk_en};

  AST_RST_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_pcs_rst) |-> $past(rx_pcs_rst, 2)); // R5

endmodule

// File: tb/sim_lpbk_switch_ctrl.sv
module sim_lpbk_switch_ctrl;
  localparam int HOLD_CFG = 1;   // below minimum: clamps to 2
  localparam int HOLD_EXP = 2;
  localparam int TMO      = 12;
  localparam int CFG_DLY  = 3;
  localparam int LOCK_DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic recfg_done = 1'b0;
  logic align_lock = 1'b0;
  logic req_ack, ser_lpbk_en, prbs_mode_en, rx_pcs_rst, chan_ready, align_err;
  logic [1:0] mode_stat;

  always #10 clk = ~clk;

  lpbk_switch_ctrl #(.HOLD_CYC(HOLD_CFG), .ALIGN_TMO(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_ack(req_ack), .recfg_done(recfg_done), .align_lock(align_lock),
    .ser_lpbk_en(ser_lpbk_en), .prbs_mode_en(prbs_mode_en),
    .rx_pcs_rst(rx_pcs_rst), .mode_stat(mode_stat),
    .chan_ready(chan_ready), .align_err(align_err)
  );

  typedef struct {int mode; int rst_cyc; int err;} exp_t;
  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  int cur_mode = 0;
  int lock_block = 0;
  bit first_req = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Reconfiguration engine model
  initial begin
    logic prbs_seen;
    prbs_seen = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && (prbs_mode_en != prbs_seen)) begin
        prbs_seen = prbs_mode_en;
        repeat (CFG_DLY) @(negedge clk);
        recfg_done = 1'b1;
        @(negedge clk);
        recfg_done = 1'b0;
      end
    end
  end

  // Word aligner model: no lock under reset, lock LOCK_DLY cycles after release
  initial begin
    logic prev_rst;
    int   lock_cnt;
    prev_rst = 1'b0;
    lock_cnt = -1;
    forever begin
      @(negedge clk);
      if (rx_pcs_rst) begin
        align_lock = 1'b0;
        lock_cnt   = -1;
      end else if (prev_rst) begin
        if (lock_block > 0) begin
          lock_block--;
          lock_cnt = -1;
        end else begin
          lock_cnt = LOCK_DLY;
        end
      end else if (lock_cnt > 0) begin
        lock_cnt--;
        if (lock_cnt == 0) align_lock = 1'b1;
      end
      prev_rst = rx_pcs_rst;
    end
  end

  // Driver: issue a request and push the expected outcome
  task automatic send(input int m, input int nfail);
    int   nm;
    bit   serchg, cfg;
    exp_t e;
    nm     = (m == 3) ? 0 : m;
    serchg = (cur_mode == 1) != (nm == 1);
    cfg    = (cur_mode == 2) != (nm == 2);
    @(negedge clk);
    req_valid = 1'b1;
    req_mode  = m[1:0];
    forever begin
      #1;
      if (req_ack) break;
      @(negedge clk);
    end
    // R2: acceptance only when idle (first) or ready
    chk(first_req || chan_ready, "R2", "ack while busy", int'(chan_ready), 1);
    first_req  = 1'b0;
    lock_block = nfail;
    e.mode     = nm;
    e.rst_cyc  = (serchg ? (1 + (cfg ? CFG_DLY + 1 : 0)) : 0) + HOLD_EXP * (1 + nfail);
    e.err      = (nfail > 0) ? 1 : 0;
    sb_q.push_back(e);
    cur_mode = nm;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // Monitor: measure each switch and compare with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (rst_n && req_valid && req_ack) begin
        int   rcnt, viol, n;
        logic prev_ser;
        exp_t e;
        rcnt = 0; viol = 0; n = 0;
        prev_ser = ser_lpbk_en;
        @(negedge clk);
        #2;
        chk(!chan_ready, "R9", "ready after accept", int'(chan_ready), 0);
        while (!chan_ready && n < 400) begin
          if (rx_pcs_rst) rcnt++;
          if ((ser_lpbk_en != prev_ser) && !rx_pcs_rst) viol++;
          prev_ser = ser_lpbk_en;
          n++;
          @(negedge clk);
          #2;
        end
        chk(chan_ready, "R7", "ready reached", int'(chan_ready), 1);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected switch", 1, 0);
        end else begin
          e = sb_q.pop_front();
          chk(int'(mode_stat) == e.mode, "R3", "mode_stat", int'(mode_stat), e.mode);
          chk(int'(ser_lpbk_en) == int'(e.mode == 1), "R3", "ser_lpbk_en",
              int'(ser_lpbk_en), int'(e.mode == 1));
          chk(int'(prbs_mode_en) == int'(e.mode == 2), "R3", "prbs_mode_en",
              int'(prbs_mode_en), int'(e.mode == 2));
          chk(rcnt == e.rst_cyc, "R5/R6", "reset cycles", rcnt, e.rst_cyc);
          chk(int'(align_err) == e.err, "R8", "align_err", int'(align_err), e.err);
          chk(viol == 0, "R4", "serial change outside reset", viol, 0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(mode_stat == 2'b00, "R1", "mode_stat", int'(mode_stat), 0);
    chk(!ser_lpbk_en && !prbs_mode_en, "R1", "enables", int'({prbs_mode_en, ser_lpbk_en}), 0);
    chk(!rx_pcs_rst, "R1", "rx_pcs_rst", int'(rx_pcs_rst), 0);
    chk(!chan_ready, "R1", "chan_ready", int'(chan_ready), 0);
    chk(!align_err, "R1", "align_err", int'(align_err), 0);
    chk(!req_ack, "R2", "ack without valid", int'(req_ack), 0);

    send(1, 0);  // R4 normal -> serial
    send(0, 0);  // R4 serial -> normal
    send(2, 0);  // R6 normal -> parallel, reset after reconfiguration only
    send(1, 0);  // R4 R6 parallel -> serial
    send(2, 1);  // R8 serial -> parallel with one alignment timeout
    send(0, 0);  // R8 error cleared on new request
    send(3, 0);  // R3 code 11 taken as normal
    send(1, 2);  // R8 two timeouts
    send(2, 0);  // R2 back-to-back request held until ready
    send(1, 0);

    begin
      int w;
      w = 0;
      while (sb_q.size() != 0 && w < 2000) begin
        @(negedge clk);
        w++;
      end
    end
    repeat (5) @(negedge clk);
    chk(sb_q.size() == 0, "R2", "pending switches", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule